// File: doc/BRIEF.md
# Two-Phase Instruction Sequencer

This block is the control sequencer of a word-oriented processor whose 40-bit memory words each carry two 20-bit instructions. It reads a word, hands the upper (left) instruction to an execution unit, then the lower (right) instruction, then moves on to the next word. Control transfers are handled inside the sequencer and are never passed to the execution unit. A transfer names both a target word and the half of that word where execution resumes.

Every instruction carries a step bit. When the step bit is clear on an ordinary instruction, the machine halts once that instruction completes. Some opcodes are only legal in one half of a word. An opcode in the wrong half raises an illegal-placement flag and halts the machine without issuing it. A resume pulse restarts execution at the instruction after the one that halted.

The execution unit sees an opcode, an address and a phase. It holds the sequencer with a valid/done handshake and supplies the sign of the accumulator for conditional transfers.

Top module: `seq_top`

## Requirements
- R1: A memory word holds the left instruction in bits 39:20 and the right instruction in bits 19:0. Each instruction has its opcode in bits 19:10 and its address in bits 9:0. Opcode bit 9 is the step bit. The low nine opcode bits, read as octal, select the class.
- R2: After reset the sequencer is running, not halted, with no illegal flag. It fetches word 0 and starts in the left phase. Read data is taken the cycle after `mem_rd_en`.
- R3: The left instruction of a word is issued before the right one, with `issue_phase` 0 and 1 respectively. After the right instruction the next word (address + 1) is fetched.
- R4: When an ordinary instruction completes with its step bit at 0, the sequencer sets `halted`. While halted it neither fetches nor issues.
- R5: A `resume` pulse while halted clears `halted` and continues with the instruction that follows the halting one, keeping its word and phase.
- R6: Code 640 is an unconditional transfer. The next instruction comes from the word named by its address, in the phase equal to the current phase XOR the step bit. `r3_clear` pulses once, and the transfer is not issued.
- R7: Code 660 is a conditional transfer. It acts as R6 when `r1_sign` is 0. When `r1_sign` is 1 it falls through to the next instruction with no `r3_clear` pulse and no halt.
- R8: The left-only codes are: odd codes 701 to 777, plus 010, 116, 210, 220, 230, 316, 326 and 336. Every other code from 200 to 377 is right-only. A code in the wrong phase is not issued; the sequencer sets `illegal_phase` and halts, and resume continues after it.
- R9: A card-input code (010) in the left phase whose right partner is not a transfer (640 or 660) is treated as illegal under R8.
- R10: `issue_valid` and the issued fields hold steady until `exec_done`. `exec_done` may arrive in the first issue cycle.
- R11: `illegal_phase` is clear again once a resume is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 10 | Word address being read |
| mem_rd_data | input | 40 | Read data, valid one cycle after the strobe |
| issue_valid | output | 1 | An instruction is offered to the execution unit |
| issue_opcode | output | 10 | Opcode of the offered instruction |
| issue_addr | output | 10 | Address field of the offered instruction |
| issue_phase | output | 1 | 0 = left half, 1 = right half |
| exec_done | input | 1 | Execution unit finished the offered instruction |
| r1_sign | input | 1 | Accumulator sign, 1 = negative |
| resume | input | 1 | Restart pulse while halted |
| halted | output | 1 | Machine is stopped |
| illegal_phase | output | 1 | Last stop was caused by an opcode in the wrong phase |
| r3_clear | output | 1 | Pulse: a transfer was taken, clear the memory register |

## Verification
The hardest situations to reach are a transfer that lands in the right half of its target word and a halt that leaves the resume point in the right half. In both, the left instruction of the fetched word must be skipped without being issued.

The stimulus program reaches the first case with a step-bit transfer from the left phase. It reaches the second by placing misplaced or step-clear instructions in left halves.

The accumulator sign is flipped by the bench's execution model only after a chosen instruction is seen. This lets one conditional transfer be taken and a later one fall through within the same run.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int OP_W   = 10;
    localparam int CODE_W = OP_W - 1;

    typedef enum logic [2:0] {
        ST_FETCH, ST_WAIT, ST_DISPATCH, ST_EXEC, ST_HALT
    } seq_state_e;

    localparam logic [CODE_W-1:0] CODE_JUMP    = 9'o640;
    localparam logic [CODE_W-1:0] CODE_BRANCH  = 9'o660;
    localparam logic [CODE_W-1:0] CODE_CARD_IN = 9'o010;

    function automatic logic left_only(input logic [CODE_W-1:0] c);
        return (c[8:6] == 3'o7 && c[0]) || c == 9'o010 || c == 9'o116 ||
               c == 9'o210 || c == 9'o220 || c == 9'o230 ||
               c == 9'o316 || c == 9'o326 || c == 9'o336;
    endfunction

    function automatic logic right_only(input logic [CODE_W-1:0] c);
        return (c[8:7] == 2'b01) && !left_only(c);
    endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int INSTR_W = OP_W + ADDR_W,
    localparam int WORD_W  = 2 * INSTR_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              phase,
    output logic [OP_W-1:0]   op,
    output logic [ADDR_W-1:0] addr,
    output logic              is_jump,
    output logic              is_branch,
    output logic              misplaced
);
    logic [INSTR_W-1:0] left_w, right_w, cur_w;
    logic [CODE_W-1:0]  code, right_code;
    logic               partner_ok;

    always_comb begin
        left_w     = word[WORD_W-1:INSTR_W];
        right_w    = word[INSTR_W-1:0];
        cur_w      = phase ? right_w : left_w;
        op         = cur_w[INSTR_W-1:ADDR_W];
        addr       = cur_w[ADDR_W-1:0];
        code       = op[CODE_W-1:0];
        right_code = right_w[INSTR_W-2:ADDR_W];
        is_jump    = (code == CODE_JUMP);
        is_branch  = (code == CODE_BRANCH);
        partner_ok = (right_code == CODE_JUMP) || (right_code == CODE_BRANCH);
        misplaced  = (phase && left_only(code)) ||
                     (!phase && right_only(code)) ||
                     (!phase && code == CODE_CARD_IN && !partner_ok);
    end
endmodule

// File: rtl/seq_advance.sv
module seq_advance #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              phase,
    output logic [ADDR_W-1:0] next_pc,
    output logic              next_phase,
    output logic              crosses
);
    always_comb begin
        crosses    = phase;
        next_phase = !phase;
        next_pc    = phase ? pc + ADDR_W'(1) : pc;
    end
endmodule

// File: rtl/seq_top.sv
module seq_top
    import seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int WORD_W = 2 * (OP_W + ADDR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              issue_valid,
    output logic [OP_W-1:0]   issue_opcode,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              issue_phase,
    input  logic              exec_done,
    input  logic              r1_sign,
    input  logic              resume,
    output logic              halted,
    output logic              illegal_phase,
    output logic              r3_clear
);
    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic              phase;
        logic [WORD_W-1:0] word;
        logic              halted;
        logic              illegal;
        logic              r3clr;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;

    logic [OP_W-1:0]   dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_jump, dec_branch, dec_bad;
    logic [ADDR_W-1:0] adv_pc;
    logic              adv_phase, adv_cross;

    seq_decode #(.ADDR_W(ADDR_W)) decode_i (
        .word(regs_q.word), .phase(regs_q.phase), .op(dec_op), .addr(dec_addr),
        .is_jump(dec_jump), .is_branch(dec_branch), .misplaced(dec_bad)
    );

    seq_advance #(.ADDR_W(ADDR_W)) advance_i (
        .pc(regs_q.pc), .phase(regs_q.phase), .next_pc(adv_pc),
        .next_phase(adv_phase), .crosses(adv_cross)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.r3clr = 1'b0;
        unique case (regs_q.state)
            ST_FETCH: regs_d.state = ST_WAIT;
            ST_WAIT: begin
                regs_d.word  = mem_rd_data;
                regs_d.state = ST_DISPATCH;
            end
            ST_DISPATCH: begin
                if (dec_bad) begin
                    regs_d.pc      = adv_pc;
                    regs_d.phase   = adv_phase;
                    regs_d.halted  = 1'b1;
                    regs_d.illegal = 1'b1;
                    regs_d.state   = ST_HALT;
                end else if (dec_jump || (dec_branch && !r1_sign)) begin
                    regs_d.pc    = dec_addr;
                    regs_d.phase = regs_q.phase ^ dec_op[OP_W-1];
                    regs_d.r3clr = 1'b1;
                    regs_d.state = ST_FETCH;
                end else if (dec_branch) begin
                    regs_d.pc    = adv_pc;
                    regs_d.phase = adv_phase;
                    regs_d.state = adv_cross ? ST_FETCH : ST_DISPATCH;
                end else begin
                    regs_d.state = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (exec_done) begin
                    regs_d.pc    = adv_pc;
                    regs_d.phase = adv_phase;
                    if (!dec_op[OP_W-1]) begin
                        regs_d.halted = 1'b1;
                        regs_d.state  = ST_HALT;
                    end else begin
                        regs_d.state = adv_cross ? ST_FETCH : ST_DISPATCH;
                    end
                end
            end
            ST_HALT: begin
                if (resume) begin
                    regs_d.halted  = 1'b0;
                    regs_d.illegal = 1'b0;
                    regs_d.state   = ST_FETCH;
                end
            end
            default: regs_d.state = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_FETCH, pc: '0, phase: 1'b0, word: '0,
                        halted: 1'b0, illegal: 1'b0, r3clr: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_rd_en     = (regs_q.state == ST_FETCH);
    assign mem_rd_addr   = regs_q.pc;
    assign issue_valid   = (regs_q.state == ST_EXEC);
    assign issue_opcode  = dec_op;
    assign issue_addr    = dec_addr;
    assign issue_phase   = regs_q.phase;
    assign halted        = regs_q.halted;
    assign illegal_phase = regs_q.illegal;
    assign r3_clear      = regs_q.r3clr;

    assert_step_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && exec_done && !issue_opcode[OP_W-1] |=> halted);
    assert_quiet_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !issue_valid && !mem_rd_en);
    assert_resume_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halted && resume |=> !halted);
    assert_transfer_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r3_clear |-> mem_rd_en);
    assert_misplaced_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_phase |-> halted);
    assert_issue_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !exec_done |=> issue_valid && $stable(issue_opcode) && $stable(issue_addr));
    assert_flag_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted && resume |=> !illegal_phase);
endmodule

// File: tb/seq_top_tb_top.sv
module seq_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        mem_rd_en, issue_valid, issue_phase, halted, illegal_phase, r3_clear;
    logic [9:0]  mem_rd_addr, issue_opcode, issue_addr;
    logic [39:0] mem_rd_data;
    logic        exec_done, r1_sign, resume;

    seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .issue_valid(issue_valid), .issue_opcode(issue_opcode),
        .issue_addr(issue_addr), .issue_phase(issue_phase), .exec_done(exec_done),
        .r1_sign(r1_sign), .resume(resume), .halted(halted),
        .illegal_phase(illegal_phase), .r3_clear(r3_clear)
    );

    int errors = 0;
    int checks = 0;
    int r3_pulses = 0;
    logic first_fetch_seen = 1'b0;
    logic finished = 1'b0;

    typedef struct packed { logic ph; logic [9:0] op; logic [9:0] ad; } item_t;
    item_t exp_q[$];

    logic [39:0] mem [0:1023];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic ph, input logic [9:0] op, input logic [9:0] ad);
        exp_q.push_back({ph, op, ad});
    endtask

    function automatic logic [39:0] mkw(input logic [9:0] lo, input logic [9:0] la,
                                        input logic [9:0] ro, input logic [9:0] ra);
        return {lo, la, ro, ra};
    endfunction

    // memory model, one cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    // execution unit model
    int ecnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            ecnt <= 0; exec_done <= 1'b0;
        end else if (issue_valid && !exec_done) begin
            if (ecnt == 2) begin exec_done <= 1'b1; ecnt <= 0; end
            else ecnt <= ecnt + 1;
        end else begin
            exec_done <= 1'b0; ecnt <= 0;
        end
    end

    // monitor / scoreboard
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (r3_clear) r3_pulses++;
            if (mem_rd_en && !first_fetch_seen) begin
                first_fetch_seen = 1'b1;
                chk(mem_rd_addr == 10'd0, "R2 first fetch address", 32'(mem_rd_addr), 0);
            end
            if (issue_valid && !prev_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected issue", {11'd0, issue_phase, issue_opcode, issue_addr}, 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk({issue_phase, issue_opcode, issue_addr} == e,
                        "R1/R3/R6 issue order", {11'd0, issue_phase, issue_opcode, issue_addr}, {11'd0, e});
                end
                if (issue_phase == 1'b0 && issue_opcode == 10'o1730) r1_sign = 1'b1;
            end
            prev_valid = issue_valid;
        end
    end

    task automatic wait_halt(input string tag, input logic exp_ill);
        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
        chk(halted, {tag, " halted"}, 32'(halted), 1);
        chk(illegal_phase == exp_ill, {tag, " illegal flag"}, 32'(illegal_phase), 32'(exp_ill));
        chk(exp_q.size() == 0, {tag, " pending issues"}, exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(!issue_valid && !mem_rd_en, "R4 quiet while halted", {issue_valid, mem_rd_en}, 0);
    endtask

    task automatic do_resume();
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        chk(!halted && !illegal_phase, "R5/R11 resume clears", {halted, illegal_phase}, 0);
    endtask

    initial begin
        resume = 1'b0; r1_sign = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[0]  = mkw(10'o1712, 10'd5,  10'o1710, 10'd6);
        mem[1]  = mkw(10'o1640, 10'd3,  10'o1712, 10'd7);
        mem[3]  = mkw(10'o1777, 10'd0,  10'o1714, 10'd9);
        mem[4]  = mkw(10'o0660, 10'd6,  10'o1712, 10'd0);
        mem[6]  = mkw(10'o1730, 10'd1,  10'o1660, 10'd8);
        mem[7]  = mkw(10'o0712, 10'd2,  10'o1500, 10'd3);
        mem[8]  = mkw(10'o1200, 10'd0,  10'o1716, 10'd4);
        mem[9]  = mkw(10'o1010, 10'd0,  10'o1712, 10'd11);
        mem[10] = mkw(10'o1010, 10'd20, 10'o1640, 10'd12);
        mem[12] = mkw(10'o1711, 10'd0,  10'o1711, 10'd0);
        mem[13] = mkw(10'o0500, 10'd1,  10'o1712, 10'd0);

        repeat (3) @(negedge clk);
        chk(!halted && !illegal_phase && !issue_valid && !r3_clear, "R2 reset outputs",
            {halted, illegal_phase, issue_valid, r3_clear}, 0);
        chk(mem_rd_addr == 10'd0, "R2 reset address", 32'(mem_rd_addr), 0);

        // segment 1: R3 ordering, R6 jump to right phase, R7 taken and not taken, R4 halt
        push_exp(1'b0, 10'o1712, 10'd5);
        push_exp(1'b1, 10'o1710, 10'd6);
        push_exp(1'b1, 10'o1714, 10'd9);
        push_exp(1'b0, 10'o1730, 10'd1);
        push_exp(1'b0, 10'o0712, 10'd2);
        @(negedge clk); rst_n = 1'b1;
        wait_halt("R4 step-clear", 1'b0);
        chk(r3_pulses == 2, "R6/R7 r3_clear count", r3_pulses, 2);

        // segment 2: R5 resume into right half, R8 right-only code in left
        push_exp(1'b1, 10'o1500, 10'd3);
        do_resume();
        wait_halt("R8 right-only in left", 1'b1);

        // segment 3: R9 card input without transfer partner
        push_exp(1'b1, 10'o1716, 10'd4);
        do_resume();
        wait_halt("R9 card input partner", 1'b1);

        // segment 4: legal card input + jump, R8 left-only code in right
        push_exp(1'b1, 10'o1712, 10'd11);
        push_exp(1'b0, 10'o1010, 10'd20);
        push_exp(1'b0, 10'o1711, 10'd0);
        do_resume();
        wait_halt("R8 left-only in right", 1'b1);
        chk(r3_pulses == 3, "R6 r3_clear after right jump", r3_pulses, 3);

        // segment 5: R11 flag cleared, final step-clear halt
        push_exp(1'b0, 10'o0500, 10'd1);
        do_resume();
        wait_halt("R4 final", 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule